// File: doc/BRIEF.md
# Halfword Store Execute Unit

This unit accepts a single store-halfword instruction word, either a 16-bit short encoding or a 32-bit wide encoding, and carries it out completely. In the cycle the word is presented, the unit decodes it. It drives the register numbers it needs onto three combinational register-file read ports and computes the effective address from the values returned. It then registers one memory write request. That request is a 16-bit store placed on a 32-bit write bus with byte enables, using a valid/ready handshake.

Several addressing variants share this one opcode family. The offset can be an immediate or a shifted register. It can be added to or subtracted from the base. The address can be formed before the base update (pre-indexed) or from the untouched base (post-indexed). Forms that update the base return a writeback of the new base value. That writeback goes out only after the memory write has been accepted, and a busy output holds off further instructions until the sequence ends. Words that match no known form raise a one-cycle undefined flag. Odd addresses raise a one-cycle alignment fault. In both cases nothing is written to memory and no register is updated.

Top module: `hstore_unit`

## Requirements
- R1: A wide word (instr_wide=1) whose bits [31:20] are 12'hF8A stores Rt[19..16 is base Rn, 15..12 is Rt] at Rn plus the zero-extended 12-bit offset in [11:0], with no writeback.
- R2: A wide word with [31:20]=12'hF82 and [11:8]=4'b1100 stores at Rn minus the 8-bit offset in [7:0], with no writeback.
- R3: A wide word with [31:20]=12'hF82 and [11:8]=1,0,U,1 stores at the unmodified Rn and writes back Rn plus the offset in [7:0] (U=1) or Rn minus it (U=0).
- R4: A wide word with [31:20]=12'hF82 and [11:8]=1,1,U,1 stores at Rn plus or minus the offset in [7:0], chosen by U, and writes back that same address to Rn.
- R5: A wide word with [31:20]=12'hF82 and [11:6]=6'b000000 stores at Rn + (Rm << s), where Rm is in [3:0] and s is in [5:4]. It has no writeback.
- R6: A short word (instr_wide=0) whose bits [15:11] are 5'b10000 stores at Rn + 2*imm5, with imm5 in [10:6], Rn in [5:3] and Rt in [2:0]. It has no writeback.
- R7: A short word with [15:9]=7'b0101001 stores at Rn + Rm, with Rm in [8:6], Rn in [5:3] and Rt in [2:0]. It has no writeback.
- R8: A write request carries Rt[15:0] on both halves of mem_wdata. mem_be is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R9: When the store address has bit 0 set, align_fault pulses for one cycle in the cycle after acceptance. No write request and no writeback follow.
- R10: mem_req_valid rises in the cycle after the instruction is accepted and stays high with unchanged address, data and enables until the cycle in which mem_req_ready is high.
- R11: For a writeback form, wb_valid pulses for exactly one cycle in the cycle after the write is accepted, carrying the base register number and the new base. busy is high from the request through that pulse, and an instruction presented while busy is ignored.
- R12: A word matching none of the forms of R1 to R7 pulses undef_flag in the next cycle, with no write request, no writeback and busy low.
- R13: After reset, busy, mem_req_valid, wb_valid, undef_flag and align_fault are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_wide | input | 1 | 1: 32-bit word, 0: 16-bit word in bits [15:0] |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | Unit is sequencing a store; new words are ignored |
| rd_base_idx | output | 4 | Base register number |
| rd_base_data | input | 32 | Base register value |
| rd_src_idx | output | 4 | Source register number |
| rd_src_data | input | 32 | Source register value |
| rd_off_idx | output | 4 | Offset register number |
| rd_off_data | input | 32 | Offset register value |
| mem_req_valid | output | 1 | Write request valid |
| mem_req_ready | input | 1 | Write request accepted |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data, halfword replicated |
| mem_be | output | 4 | Byte enables |
| wb_valid | output | 1 | Base writeback pulse |
| wb_idx | output | 4 | Writeback register number |
| wb_data | output | 32 | Writeback value |
| undef_flag | output | 1 | Undefined-word pulse |
| align_fault | output | 1 | Misaligned-address pulse |

## Verification
The bench targets the split between memory address and base update. It includes post-indexed stores whose write address must be the old base while the writeback carries the updated one; a design that mixed these up would write to the updated address. Subtract variants and the shifted-register offset are each covered, so a dropped sign or a missing shift shows up as a wrong address. The bench also holds ready low while presenting a second word to the busy unit; a design that accepted it would change the held request or issue an extra write. Odd addresses, including an odd base in post-indexed form, and near-miss encodings check that faults and undefined words leave the memory and writeback ports silent.

// File: rtl/hstore_pkg.sv
package hstore_pkg;

    localparam int RIDX_W = 4;
    localparam int IMM_W  = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WB   = 2'd2
    } st_e;

    // One decoded store: where the offset comes from and how it is applied
    typedef struct packed {
        logic              legal;
        logic              add;
        logic              index;
        logic              wback;
        logic              use_reg;
        logic [1:0]        shamt;
        logic [IMM_W-1:0]  imm;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rm;
    } dec_t;

endpackage

// File: rtl/hstore_decode.sv
module hstore_decode
    import hstore_pkg::*;
(
    input  logic [31:0] word,
    input  logic        wide,
    output dec_t        dec
);

    always_comb begin
        dec       = '0;
        dec.add   = 1'b1;
        dec.index = 1'b1;
        if (wide) begin
            dec.rn = word[19:16];
            dec.rt = word[15:12];
            if (word[31:20] == 12'hF8A) begin
                dec.legal = 1'b1;
                dec.imm   = word[11:0];
            end else if (word[31:20] == 12'hF82) begin
                if (word[11]) begin
                    dec.imm = {4'b0, word[7:0]};
                    unique case (word[10:8])
                        3'b100: begin
                            dec.legal = 1'b1;
                            dec.add   = 1'b0;
                        end
                        3'b001, 3'b011: begin
                            dec.legal = 1'b1;
                            dec.add   = word[9];
                            dec.index = 1'b0;
                            dec.wback = 1'b1;
                        end
                        3'b101, 3'b111: begin
                            dec.legal = 1'b1;
                            dec.add   = word[9];
                            dec.wback = 1'b1;
                        end
                        default: dec.legal = 1'b0;
                    endcase
                end else if (word[10:6] == 5'b00000) begin
                    dec.legal   = 1'b1;
                    dec.use_reg = 1'b1;
                    dec.rm      = word[3:0];
                    dec.shamt   = word[5:4];
                end
            end
        end else begin
            dec.rn = {1'b0, word[5:3]};
            dec.rt = {1'b0, word[2:0]};
            if (word[15:11] == 5'b10000) begin
                dec.legal = 1'b1;
                dec.imm   = {6'b0, word[10:6], 1'b0};
            end else if (word[15:9] == 7'b0101001) begin
                dec.legal   = 1'b1;
                dec.use_reg = 1'b1;
                dec.rm      = {1'b0, word[8:6]};
            end
        end
    end

endmodule

// File: rtl/hstore_agu.sv
module hstore_agu
    import hstore_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] off_reg,
    output logic [XLEN-1:0] store_addr,
    output logic [XLEN-1:0] upd_addr
);

    logic [XLEN-1:0] offset;

    always_comb begin
        if (dec.use_reg) begin
            offset = off_reg << dec.shamt;
        end else begin
            offset = {{(XLEN-IMM_W){1'b0}}, dec.imm};
        end
        upd_addr   = dec.add ? (base + offset) : (base - offset);
        store_addr = dec.index ? upd_addr : base;
    end

endmodule

// File: rtl/hstore_lane.sv
module hstore_lane #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   addr,
    input  logic [15:0]       half,
    output logic [XLEN/8-1:0] be,
    output logic [XLEN-1:0]   wdata,
    output logic              misaligned
);

    localparam int NH     = XLEN / 16;
    localparam int LSEL_W = $clog2(NH);

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign be[2*h +: 2]     = (addr[LSEL_W:1] == LSEL_W'(h)) ? 2'b11 : 2'b00;
        assign wdata[16*h +: 16] = half;
    end

    assign misaligned = addr[0];

endmodule

// File: rtl/hstore_unit.sv
module hstore_unit
    import hstore_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              instr_wide,
    input  logic [31:0]       instr_word,
    output logic              busy,
    output logic [RIDX_W-1:0] rd_base_idx,
    input  logic [XLEN-1:0]   rd_base_data,
    output logic [RIDX_W-1:0] rd_src_idx,
    input  logic [XLEN-1:0]   rd_src_data,
    output logic [RIDX_W-1:0] rd_off_idx,
    input  logic [XLEN-1:0]   rd_off_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN/8-1:0] mem_be,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              undef_flag,
    output logic              align_fault
);

    localparam int BE_W = XLEN / 8;

    typedef struct packed {
        st_e               st;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [BE_W-1:0]   be;
        logic              wb_en;
        logic [RIDX_W-1:0] wb_idx;
        logic [XLEN-1:0]   wb_data;
        logic              undef;
        logic              fault;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    dec_t            dec;
    logic [XLEN-1:0] store_addr;
    logic [XLEN-1:0] upd_addr;
    logic [BE_W-1:0] lane_be;
    logic [XLEN-1:0] lane_wdata;
    logic            misaligned;
    logic            src_hi_unused;

    assign src_hi_unused = ^rd_src_data[XLEN-1:16];

    hstore_decode i_decode (
        .word (instr_word),
        .wide (instr_wide),
        .dec  (dec)
    );

    hstore_agu #(.XLEN(XLEN)) i_agu (
        .dec        (dec),
        .base       (rd_base_data),
        .off_reg    (rd_off_data),
        .store_addr (store_addr),
        .upd_addr   (upd_addr)
    );

    hstore_lane #(.XLEN(XLEN)) i_lane (
        .addr       (store_addr),
        .half       (rd_src_data[15:0]),
        .be         (lane_be),
        .wdata      (lane_wdata),
        .misaligned (misaligned)
    );

    assign rd_base_idx = dec.rn;
    assign rd_src_idx  = dec.rt;
    assign rd_off_idx  = dec.rm;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.undef = 1'b0;
        ctl_d.fault = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (!dec.legal) begin
                        ctl_d.undef = 1'b1;
                    end else if (misaligned) begin
                        ctl_d.fault = 1'b1;
                    end else begin
                        ctl_d.st      = ST_REQ;
                        ctl_d.addr    = store_addr;
                        ctl_d.wdata   = lane_wdata;
                        ctl_d.be      = lane_be;
                        ctl_d.wb_en   = dec.wback;
                        ctl_d.wb_idx  = dec.rn;
                        ctl_d.wb_data = upd_addr;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.st = ctl_q.wb_en ? ST_WB : ST_IDLE;
                end
            end
            ST_WB: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy          = (ctl_q.st != ST_IDLE);
    assign mem_req_valid = (ctl_q.st == ST_REQ);
    assign mem_addr      = ctl_q.addr;
    assign mem_wdata     = ctl_q.wdata;
    assign mem_be        = ctl_q.be;
    assign wb_valid      = (ctl_q.st == ST_WB);
    assign wb_idx        = ctl_q.wb_idx;
    assign wb_data       = ctl_q.wb_data;
    assign undef_flag    = ctl_q.undef;
    assign align_fault   = ctl_q.fault;

endmodule

// File: rtl/hstore_checker.sv
module hstore_checker #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic [XLEN/8-1:0] mem_be,
    input logic              wb_valid,
    input logic              undef_flag,
    input logic              align_fault
);

    assert_req_even_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_addr[0]);

    assert_two_byte_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ($countones(mem_be) == 2));

    assert_half_replicated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_wdata[XLEN-1 -: 16] == mem_wdata[15:0]));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)));

    assert_wb_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_req_valid && mem_req_ready));

    assert_wb_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_busy_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || wb_valid) |-> busy);

    assert_undef_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (!mem_req_valid && !wb_valid && !busy));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!mem_req_valid && !wb_valid && !busy));

endmodule

bind hstore_unit hstore_checker #(.XLEN(XLEN)) i_hstore_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_be        (mem_be),
    .wb_valid      (wb_valid),
    .undef_flag    (undef_flag),
    .align_fault   (align_fault)
);

// File: tb/test_hstore_unit.sv
module test_hstore_unit;

    logic        clk;
    logic        rst_n;
    logic        instr_valid;
    logic        instr_wide;
    logic [31:0] instr_word;
    logic        busy;
    logic [3:0]  rd_base_idx, rd_src_idx, rd_off_idx;
    logic [31:0] rd_base_data, rd_src_data, rd_off_data;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        wb_valid;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        undef_flag, align_fault;

    logic [31:0] regs [16];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        bit          undef;
        bit          fault;
        bit          wb;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [3:0]  wbidx;
        logic [31:0] wbdata;
    } exp_t;

    assign rd_base_data = regs[rd_base_idx];
    assign rd_src_data  = regs[rd_src_idx];
    assign rd_off_data  = regs[rd_off_idx];

    hstore_unit i_hstore_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_wide    (instr_wide),
        .instr_word    (instr_word),
        .busy          (busy),
        .rd_base_idx   (rd_base_idx),
        .rd_base_data  (rd_base_data),
        .rd_src_idx    (rd_src_idx),
        .rd_src_data   (rd_src_data),
        .rd_off_idx    (rd_off_idx),
        .rd_off_data   (rd_off_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_be        (mem_be),
        .wb_valid      (wb_valid),
        .wb_idx        (wb_idx),
        .wb_data       (wb_data),
        .undef_flag    (undef_flag),
        .align_fault   (align_fault)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural expectation derived from the requirement text
    function automatic exp_t model(input logic [31:0] w, input bit wide);
        exp_t e;
        bit ok = 0, add = 1, idx = 1, wb = 0;
        int rn = 0, rt = 0;
        logic [31:0] off = 0, base, upd, addr;
        if (wide) begin
            rn = int'(w[19:16]);
            rt = int'(w[15:12]);
            if (w[31:20] == 12'hF8A) begin
                ok = 1; off = 32'(w[11:0]);
            end else if (w[31:20] == 12'hF82 && w[11:8] == 4'b1100) begin
                ok = 1; add = 0; off = 32'(w[7:0]);
            end else if (w[31:20] == 12'hF82 && w[11] && !w[10] && w[8]) begin
                ok = 1; add = w[9]; idx = 0; wb = 1; off = 32'(w[7:0]);
            end else if (w[31:20] == 12'hF82 && w[11] && w[10] && w[8]) begin
                ok = 1; add = w[9]; wb = 1; off = 32'(w[7:0]);
            end else if (w[31:20] == 12'hF82 && w[11:6] == 6'd0) begin
                ok = 1; off = regs[w[3:0]] << w[5:4];
            end
        end else begin
            rn = int'(w[5:3]);
            rt = int'(w[2:0]);
            if (w[15:11] == 5'b10000) begin
                ok = 1; off = 32'(w[10:6]) * 2;
            end else if (w[15:9] == 7'b0101001) begin
                ok = 1; off = regs[w[8:6]];
            end
        end
        base = regs[rn];
        upd  = add ? base + off : base - off;
        addr = idx ? upd : base;
        e.undef  = !ok;
        e.fault  = ok && addr[0];
        e.wb     = wb;
        e.addr   = addr;
        e.be     = addr[1] ? 4'b1100 : 4'b0011;
        e.wdata  = {regs[rt][15:0], regs[rt][15:0]};
        e.wbidx  = 4'(rn);
        e.wbdata = upd;
        return e;
    endfunction

    task automatic exec(input logic [31:0] w, input bit wide, input int stall,
                        input bit intrude, input string req);
        exp_t e;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        instr_wide  = wide;
        e = model(w, wide);
        @(negedge clk);
        instr_valid = 1'b0;
        if (e.undef) begin
            check(undef_flag == 1'b1, "R12 undef pulse", 32'(undef_flag), 32'd1);
            check(!mem_req_valid && !busy && !wb_valid, "R12 no activity", 32'(mem_req_valid), 32'd0);
            @(negedge clk);
            check(!undef_flag && !mem_req_valid, "R12 single pulse", 32'(undef_flag), 32'd0);
            return;
        end
        if (e.fault) begin
            check(align_fault == 1'b1, "R9 fault pulse", 32'(align_fault), 32'd1);
            check(!mem_req_valid && !busy, "R9 no write", 32'(mem_req_valid), 32'd0);
            @(negedge clk);
            check(!mem_req_valid && !wb_valid && !align_fault, "R9 quiet after", 32'(mem_req_valid), 32'd0);
            return;
        end
        check(mem_req_valid == 1'b1, {req, " request raised (R10)"}, 32'(mem_req_valid), 32'd1);
        check(mem_addr == e.addr, {req, " address"}, mem_addr, e.addr);
        check(mem_be == e.be, "R8 byte enables", 32'(mem_be), 32'(e.be));
        check(mem_wdata == e.wdata, "R8 write data", mem_wdata, e.wdata);
        check(busy == 1'b1, "R11 busy during request", 32'(busy), 32'd1);
        for (int s = 0; s < stall; s++) begin
            if (intrude && s == 0) begin
                instr_valid = 1'b1;
                instr_word  = {12'hF8A, 4'd0, 4'd1, 12'h040};
                instr_wide  = 1'b1;
            end
            @(negedge clk);
            instr_valid = 1'b0;
            check(mem_req_valid && mem_addr == e.addr && mem_be == e.be && mem_wdata == e.wdata,
                  "R10 request held", mem_addr, e.addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid, "R10 request dropped after accept", 32'(mem_req_valid), 32'd0);
        if (e.wb) begin
            check(wb_valid == 1'b1, {req, " writeback pulse (R11)"}, 32'(wb_valid), 32'd1);
            check(wb_idx == e.wbidx, {req, " writeback index"}, 32'(wb_idx), 32'(e.wbidx));
            check(wb_data == e.wbdata, {req, " writeback value"}, wb_data, e.wbdata);
            check(busy == 1'b1, "R11 busy through writeback", 32'(busy), 32'd1);
            @(negedge clk);
        end
        check(!wb_valid && !busy, "R11 idle after sequence", 32'(busy), 32'd0);
        @(negedge clk);
        check(!mem_req_valid && !wb_valid, "R11 no stray request", 32'(mem_req_valid), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            regs[i] = 32'h2000_0000 + 32'(i) * 32'h100 + ((i % 2 == 1) ? 32'd2 : 32'd0);
        end
        regs[13]      = 32'h3000_0001;
        rst_n         = 1'b0;
        instr_valid   = 1'b0;
        instr_wide    = 1'b0;
        instr_word    = '0;
        mem_req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req_valid && !wb_valid && !undef_flag && !align_fault,
              "R13 reset state", {27'd0, busy, mem_req_valid, wb_valid, undef_flag, align_fault}, 32'd0);

        exec({12'hF8A, 4'd1, 4'd2, 12'h012}, 1'b1, 0, 1'b0, "R1 wide imm low lane");
        exec({12'hF8A, 4'd2, 4'd3, 12'hFFE}, 1'b1, 2, 1'b0, "R1 wide imm high lane");
        exec({12'hF82, 4'd4, 4'd5, 4'b1100, 8'h10}, 1'b1, 0, 1'b0, "R2 negative offset");
        exec({12'hF82, 4'd3, 4'd6, 4'b1011, 8'h20}, 1'b1, 0, 1'b0, "R3 post add");
        exec({12'hF82, 4'd8, 4'd7, 4'b1001, 8'h36}, 1'b1, 1, 1'b0, "R3 post sub");
        exec({12'hF82, 4'd5, 4'd4, 4'b1111, 8'h06}, 1'b1, 0, 1'b0, "R4 pre add");
        exec({12'hF82, 4'd6, 4'd9, 4'b1101, 8'h82}, 1'b1, 3, 1'b1, "R4 pre sub busy-ignore");
        exec({12'hF82, 4'd7, 4'd8, 6'b000000, 2'd2, 4'd9}, 1'b1, 0, 1'b0, "R5 shifted register");
        exec({12'hF82, 4'd10, 4'd1, 6'b000000, 2'd0, 4'd12}, 1'b1, 1, 1'b0, "R5 unshifted register");
        exec({16'h0, 5'b10000, 5'd7, 3'd2, 3'd1}, 1'b0, 0, 1'b0, "R6 short imm");
        exec({16'h0, 5'b10000, 5'd31, 3'd6, 3'd7}, 1'b0, 1, 1'b0, "R6 short imm max");
        exec({16'h0, 7'b0101001, 3'd3, 3'd4, 3'd5}, 1'b0, 0, 1'b0, "R7 short register");
        exec({12'hF8A, 4'd0, 4'd1, 12'h001}, 1'b1, 0, 1'b0, "R9 odd offset");
        exec({12'hF82, 4'd13, 4'd1, 4'b1011, 8'h02}, 1'b1, 0, 1'b0, "R9 odd base post");
        exec({12'hF8B, 4'd1, 4'd2, 12'h010}, 1'b1, 0, 1'b0, "R12 wrong top bits");
        exec({12'hF82, 4'd1, 4'd2, 4'b1000, 8'h10}, 1'b1, 0, 1'b0, "R12 bad index bits");
        exec({12'hF82, 4'd1, 4'd2, 6'b000001, 2'd0, 4'd3}, 1'b1, 0, 1'b0, "R12 bad register form");
        exec(32'h0000_5000, 1'b0, 0, 1'b0, "R12 short unknown");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule